// File: doc/BRIEF.md
# Column-streamed 3x3 smoothing filter

The block smooths an image of ROWS x COLS pixels with a 3x3 kernel. It generates its own read addresses. Each read returns one column of three vertically adjacent pixels in the same cycle: the top row of the current band plus the two rows below it. Within a band of three rows it steps one column at a time from left to right, and it handles the bands from top to bottom. The three most recent columns sit in a rotating store of nine pixels. Each new column overwrites only the third that holds the oldest column, so nothing is shifted.

A kernel-select input chooses between a uniform average (every tap weighted 1/9, computed with a fixed-point reciprocal and rounding) and a binomial kernel (1-2-1 / 2-4-2 / 1-2-1, divided by 16 with rounding). The choice is sampled once per band. Border pixels are never window centres, so a frame gives (ROWS-2) x (COLS-2) results. Each result carries a valid flag and the row and column of its centre.

The sequencer has four states. ST_IDLE waits for `start`. ST_PRIME reads the first three columns of a band. ST_SLIDE reads the remaining columns. ST_DRAIN holds for one cycle after the last read so that the final result can leave. The transitions are:
- IDLE to PRIME on `start`.
- PRIME to SLIDE once column 2 has been read.
- PRIME or SLIDE back to PRIME on the last column of a band that is not the last band.
- PRIME or SLIDE to DRAIN on the last column of the last band.
- DRAIN to IDLE unconditionally.

Top module: `colwin_smoother`

## Requirements
- R1: During and after reset, `rd_en`, `busy`, `out_vld` and `done` are 0 until `start` is given.
- R2: A `start` seen while idle makes `rd_en` high from the next cycle for exactly (ROWS-2)*COLS consecutive cycles. The addresses run as `rd_col` 0..COLS-1 within each band and `rd_band` (top row of the band) 0..ROWS-3. The pixels on `px_top`, `px_mid` and `px_bot` are taken from rows `rd_band`, `rd_band`+1 and `rd_band`+2 in the same cycle.
- R3: In each band the first result needs three column reads. A read of column c >= 2 produces `out_vld` exactly two cycles later, and no other cycle has `out_vld`.
- R4: The store keeps the three newest columns of the band. A read rewrites only the slot of the oldest column and leaves the other two untouched.
- R5: With kernel code 0 (average) the result is floor((S+4)/9), where S is the sum of the nine window pixels, clipped to the pixel range.
- R6: With kernel code 1 (binomial) the result is floor((C + 2E + 4M + 8)/16). C is the sum of the four corners, E is the sum of the four edge pixels and M is the centre pixel.
- R7: The centre reported with a read of band b, column c is row b+1, column c-1. Border pixels are never centres, and each frame gives exactly (ROWS-2)*(COLS-2) results.
- R8: `kern_sel` is sampled in the cycle that column 0 of a band is read, and that kernel applies to every result of that band. Changes in any other cycle do not affect that band.
- R9: `done` pulses for one cycle together with the last result, and `busy` is 0 from that cycle on. A `start` given while `busy` is 1 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a frame (honoured only when idle) |
| kern_sel | input | 1 | 0 = average, 1 = binomial |
| px_top | input | PIX_W | Pixel at row `rd_band`, column `rd_col` |
| px_mid | input | PIX_W | Pixel at row `rd_band`+1 |
| px_bot | input | PIX_W | Pixel at row `rd_band`+2 |
| rd_en | output | 1 | Column read strobe |
| rd_band | output | clog2(ROWS) | Top row of the band being read |
| rd_col | output | clog2(COLS) | Column being read |
| busy | output | 1 | Frame in progress |
| out_vld | output | 1 | Result valid |
| out_px | output | PIX_W | Filtered centre value |
| out_row | output | clog2(ROWS) | Centre row of the result |
| out_col | output | clog2(COLS) | Centre column of the result |
| done | output | 1 | One-cycle end-of-frame pulse |

## Verification
The bench builds the block with ROWS=5, COLS=6 and PIX_W=8. With three bands, a frame lasts only 18 reads yet still passes through both band changes, the PRIME to SLIDE step in every band, and the drain after the last band. Eight-bit pixels put the full-scale window sum within reach, which tests the reciprocal rounding of the average at its upper limit. The kernel select is flipped in the middle of bands to show that it takes effect only at the next band.

// File: rtl/colwin_pkg.sv
package colwin_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PRIME = 2'd1,
        ST_SLIDE = 2'd2,
        ST_DRAIN = 2'd3
    } seq_state_t;

    // kernel select codes
    localparam logic KER_AVG   = 1'b0;
    localparam logic KER_BINOM = 1'b1;

endpackage

// File: rtl/colwin_ring.sv
module colwin_ring #(
    parameter int PIX_W = 10,
    localparam int COLV_W = 3 * PIX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [COLV_W-1:0] wr_col,
    output logic [COLV_W-1:0] col_old,
    output logic [COLV_W-1:0] col_ctr,
    output logic [COLV_W-1:0] col_new
);

    logic [1:0]        ptr;
    logic [COLV_W-1:0] slot [3];

    function automatic logic [1:0] nxt3(input logic [1:0] v);
        return (v == 2'd2) ? 2'd0 : v + 2'd1;
    endfunction

    // ptr always marks the slot of the oldest column
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr <= 2'd0;
        end else if (wr_en) begin
            ptr <= nxt3(ptr);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < 3; i++) slot[i] <= '0;
        end else if (wr_en) begin
            for (int i = 0; i < 3; i++) begin
                if (ptr == 2'(i)) slot[i] <= wr_col;
            end
        end
    end

    always_comb begin
        unique case (ptr)
            2'd0:    begin col_old = slot[0]; col_ctr = slot[1]; col_new = slot[2]; end
            2'd1:    begin col_old = slot[1]; col_ctr = slot[2]; col_new = slot[0]; end
            default: begin col_old = slot[2]; col_ctr = slot[0]; col_new = slot[1]; end
        endcase
    end

    // R4: a read leaves the two slots that are not oldest untouched
    for (genvar gi = 0; gi < 3; gi++) begin : g_slot_chk
        a_r4_untouched_slot: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && ptr != 2'(gi)) |=> $stable(slot[gi]));
    end

    a_r4_ptr_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(ptr));

endmodule

// File: rtl/colwin_kernel.sv
module colwin_kernel #(
    parameter int PIX_W = 10,
    localparam int COLV_W = 3 * PIX_W
) (
    input  logic [COLV_W-1:0] col_old,
    input  logic [COLV_W-1:0] col_ctr,
    input  logic [COLV_W-1:0] col_new,
    input  logic              use_binom,
    output logic [PIX_W-1:0]  px
);

    localparam int SUM_W  = PIX_W + 4;
    localparam int FRAC   = PIX_W + 8;
    localparam int RECIP  = ((1 << FRAC) + 8) / 9;   // ceil(2^FRAC / 9)
    localparam int PROD_W = SUM_W + FRAC + 2;
    localparam int MAXV   = (1 << PIX_W) - 1;

    logic [SUM_W-1:0]  corners, edges, centre, plain, weighted;
    logic [PROD_W-1:0] avg_prod, avg_q, bin_q, pick;

    function automatic logic [SUM_W-1:0] ext(input logic [PIX_W-1:0] v);
        return SUM_W'(v);
    endfunction

    always_comb begin
        corners  = ext(col_old[3*PIX_W-1:2*PIX_W]) + ext(col_old[PIX_W-1:0])
                 + ext(col_new[3*PIX_W-1:2*PIX_W]) + ext(col_new[PIX_W-1:0]);
        edges    = ext(col_old[2*PIX_W-1:PIX_W]) + ext(col_new[2*PIX_W-1:PIX_W])
                 + ext(col_ctr[3*PIX_W-1:2*PIX_W]) + ext(col_ctr[PIX_W-1:0]);
        centre   = ext(col_ctr[2*PIX_W-1:PIX_W]);
        plain    = corners + edges + centre;
        weighted = corners + (edges << 1) + (centre << 2) + SUM_W'(8);
        avg_prod = PROD_W'(plain + SUM_W'(4)) * PROD_W'(RECIP);
        avg_q    = avg_prod >> FRAC;
        bin_q    = PROD_W'(weighted >> 4);
        pick     = use_binom ? bin_q : avg_q;
        px       = (pick > PROD_W'(MAXV)) ? PIX_W'(MAXV) : pick[PIX_W-1:0];
    end

endmodule

// File: rtl/colwin_smoother.sv
module colwin_smoother
    import colwin_pkg::*;
#(
    parameter int ROWS  = 480,
    parameter int COLS  = 640,
    parameter int PIX_W = 10,
    localparam int ROW_W = $clog2(ROWS),
    localparam int COL_W = $clog2(COLS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             kern_sel,
    input  logic [PIX_W-1:0] px_top,
    input  logic [PIX_W-1:0] px_mid,
    input  logic [PIX_W-1:0] px_bot,
    output logic             rd_en,
    output logic [ROW_W-1:0] rd_band,
    output logic [COL_W-1:0] rd_col,
    output logic             busy,
    output logic             out_vld,
    output logic [PIX_W-1:0] out_px,
    output logic [ROW_W-1:0] out_row,
    output logic [COL_W-1:0] out_col,
    output logic             done
);

    localparam int COLV_W = 3 * PIX_W;
    localparam logic [COL_W-1:0] LAST_C = COL_W'(COLS - 1);
    localparam logic [ROW_W-1:0] LAST_B = ROW_W'(ROWS - 3);
    localparam logic [COL_W-1:0] PRIME_END = COL_W'(2);

    seq_state_t state_q, state_d;
    logic [COL_W-1:0] col_q;
    logic [ROW_W-1:0] band_q;
    logic             ksel_q;
    logic             win_rdy_q, win_k_q;
    logic [ROW_W-1:0] cen_row_q;
    logic [COL_W-1:0] cen_col_q;
    logic [COLV_W-1:0] c_old, c_ctr, c_new;
    logic [PIX_W-1:0] k_px;
    logic             last_col;

    assign rd_en    = (state_q == ST_PRIME) || (state_q == ST_SLIDE);
    assign busy     = (state_q != ST_IDLE);
    assign rd_band  = band_q;
    assign rd_col   = col_q;
    assign last_col = (col_q == LAST_C);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start) state_d = ST_PRIME;
            ST_PRIME, ST_SLIDE: begin
                if (last_col)                    state_d = (band_q == LAST_B) ? ST_DRAIN : ST_PRIME;
                else if (col_q == PRIME_END)     state_d = ST_SLIDE;
            end
            ST_DRAIN: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // address counters, kernel latch and window-ready pipeline
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            col_q     <= '0;
            band_q    <= '0;
            ksel_q    <= KER_AVG;
            win_rdy_q <= 1'b0;
            win_k_q   <= KER_AVG;
            cen_row_q <= '0;
            cen_col_q <= '0;
        end else begin
            if (state_q == ST_IDLE && start) begin
                col_q  <= '0;
                band_q <= '0;
            end else if (rd_en) begin
                if (last_col) begin
                    col_q <= '0;
                    if (band_q != LAST_B) band_q <= band_q + ROW_W'(1);
                end else begin
                    col_q <= col_q + COL_W'(1);
                end
            end
            if (rd_en && col_q == '0) ksel_q <= kern_sel;
            win_rdy_q <= rd_en && (col_q >= PRIME_END);
            win_k_q   <= ksel_q;
            cen_row_q <= band_q + ROW_W'(1);
            cen_col_q <= col_q - COL_W'(1);
        end
    end

    colwin_ring #(.PIX_W(PIX_W)) u_ring (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (rd_en),
        .wr_col  ({px_top, px_mid, px_bot}),
        .col_old (c_old),
        .col_ctr (c_ctr),
        .col_new (c_new)
    );

    colwin_kernel #(.PIX_W(PIX_W)) u_kernel (
        .col_old   (c_old),
        .col_ctr   (c_ctr),
        .col_new   (c_new),
        .use_binom (win_k_q),
        .px        (k_px)
    );

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_vld <= 1'b0;
            out_px  <= '0;
            out_row <= '0;
            out_col <= '0;
            done    <= 1'b0;
        end else begin
            out_vld <= win_rdy_q;
            if (win_rdy_q) begin
                out_px  <= k_px;
                out_row <= cen_row_q;
                out_col <= cen_col_q;
            end
            done <= (state_q == ST_DRAIN);
        end
    end

    a_r2_addr_range: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> (rd_col <= LAST_C && rd_band <= LAST_B));

    a_r2_col_step: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_col != LAST_C) |=> (rd_en && rd_col == $past(rd_col) + COL_W'(1)));

    a_r3_result_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld |-> $past(rd_en, 2));

    a_r7_centre_inside: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld |-> (out_row >= ROW_W'(1) && out_row <= ROW_W'(ROWS - 2)
                     && out_col >= COL_W'(1) && out_col <= COL_W'(COLS - 2)));

    a_r8_kernel_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_col != '0) |=> $stable(ksel_q));

    a_r9_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

endmodule

// File: tb/sim_colwin_smoother.sv
module sim_colwin_smoother;

    localparam int CLK_PERIOD = 10;
    localparam int ROWS  = 5;
    localparam int COLS  = 6;
    localparam int PIX_W = 8;
    localparam int ROW_W = $clog2(ROWS);
    localparam int COL_W = $clog2(COLS);
    localparam int N_OUT = (ROWS - 2) * (COLS - 2);

    logic clk = 1'b0;
    logic rst_n, start, kern_sel;
    logic [PIX_W-1:0] px_top, px_mid, px_bot;
    logic rd_en, busy, out_vld, done;
    logic [ROW_W-1:0] rd_band, out_row;
    logic [COL_W-1:0] rd_col, out_col;
    logic [PIX_W-1:0] out_px;

    always #(CLK_PERIOD / 2) clk = ~clk;

    colwin_smoother #(.ROWS(ROWS), .COLS(COLS), .PIX_W(PIX_W)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .kern_sel(kern_sel),
        .px_top(px_top), .px_mid(px_mid), .px_bot(px_bot),
        .rd_en(rd_en), .rd_band(rd_band), .rd_col(rd_col), .busy(busy),
        .out_vld(out_vld), .out_px(out_px), .out_row(out_row), .out_col(out_col),
        .done(done)
    );

    int img [ROWS][COLS];
    int compared = 0, mismatched = 0;

    always_comb begin
        px_top = '0; px_mid = '0; px_bot = '0;
        if (int'(rd_band) <= ROWS - 3 && int'(rd_col) < COLS) begin
            px_top = PIX_W'(img[rd_band][rd_col]);
            px_mid = PIX_W'(img[int'(rd_band) + 1][rd_col]);
            px_bot = PIX_W'(img[int'(rd_band) + 2][rd_col]);
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, expv, $time);
        end
    endtask

    // reference result for the window whose newest column is c in band b
    function automatic int ref_px(int b, int c, bit k);
        int s = 0, w = 0;
        for (int dr = 0; dr < 3; dr++)
            for (int dc = 0; dc < 3; dc++) begin
                int v = img[b + dr][c - 2 + dc];
                s += v;
                w += v * ((dr == 1) ? 2 : 1) * ((dc == 1) ? 2 : 1);
            end
        return k ? (w + 8) / 16 : (s + 4) / 9;
    endfunction

    typedef struct { int due; int px; int row; int col; } exp_t;
    exp_t q[$];
    bit mon_on = 0, m_active = 0, pend = 0, band_k = 0, frame_done = 0;
    int cyc = 0, mb = 0, mc = 0, last_cyc = -100, frame_outs = 0;

    // cycle-by-cycle reference model, sampled away from the clock edge
    always @(negedge clk) begin
        if (mon_on) begin
            bit exp_busy, exp_v;
            cyc++;
            if (pend) begin
                m_active = 1; pend = 0; mb = 0; mc = 0; frame_outs = 0;
            end
            exp_busy = m_active || (cyc == last_cyc + 1);
            chk(busy == exp_busy, "R9 busy", busy, exp_busy);
            chk(rd_en == m_active, "R2 rd_en", rd_en, m_active);
            if (rd_en && m_active) begin
                chk(int'(rd_band) == mb, "R2 rd_band", rd_band, mb);
                chk(int'(rd_col) == mc, "R2 rd_col", rd_col, mc);
                if (mc == 0) band_k = kern_sel;          // R8 sampling point
                if (mc >= 2) q.push_back('{cyc + 2, ref_px(mb, mc, band_k), mb + 1, mc - 1});
                if (mc == COLS - 1) begin
                    mc = 0;
                    if (mb == ROWS - 3) begin m_active = 0; last_cyc = cyc; end
                    else mb++;
                end else mc++;
            end
            exp_v = (q.size() > 0) && (q[0].due == cyc);
            chk(out_vld == exp_v, "R3 out_vld timing", out_vld, exp_v);
            if (out_vld && exp_v) begin
                chk(int'(out_px) == q[0].px, "R4 R5 R6 R8 out_px", out_px, q[0].px);
                chk(int'(out_row) == q[0].row, "R7 out_row", out_row, q[0].row);
                chk(int'(out_col) == q[0].col, "R7 out_col", out_col, q[0].col);
                frame_outs++;
                void'(q.pop_front());
            end
            chk(done == (cyc == last_cyc + 2), "R9 done", done, cyc == last_cyc + 2);
            if (done) frame_done = 1;
            if (start && !busy) pend = 1;
        end
    end

    task automatic fill(input int pat);
        int lf = 32'h1ace;
        for (int r = 0; r < ROWS; r++)
            for (int c = 0; c < COLS; c++) begin
                lf = lf ^ (lf << 7); lf = lf ^ (lf >>> 9); lf = lf ^ (lf << 8);
                case (pat)
                    0: img[r][c] = 255;
                    1: img[r][c] = (r * 41 + c * 67 + 13) % 256;
                    2: img[r][c] = ((r + c) % 2) ? 255 : 0;
                    3: img[r][c] = lf & 255;
                    default: img[r][c] = 0;
                endcase
            end
    endtask

    task automatic run_frame(input int pat, input bit k0, input int flip_a,
                             input int flip_b, input int dup_start);
        int cnt = 1;
        fill(pat);
        @(posedge clk); #1;
        kern_sel = k0; start = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
        while (!frame_done && cnt < 2000) begin
            @(posedge clk); #1;
            cnt++;
            if (cnt == flip_a || cnt == flip_b) kern_sel = ~kern_sel;
            start = (cnt == dup_start);          // R9: start while busy
        end
        start = 1'b0;
        chk(frame_done, "R9 frame finished", frame_done, 1);
        chk(frame_outs == N_OUT, "R7 results per frame", frame_outs, N_OUT);
        frame_done = 0;
        repeat (3) @(posedge clk);
    endtask

    initial begin
        rst_n = 1'b0; start = 1'b0; kern_sel = 1'b0;
        fill(4);
        repeat (2) @(negedge clk);
        chk(!rd_en && !busy && !out_vld && !done, "R1 in reset", {rd_en, busy, out_vld, done}, 0);
        @(posedge clk); #1;
        rst_n = 1'b1;
        @(negedge clk);
        chk(!rd_en && !busy && !out_vld && !done, "R1 after reset", {rd_en, busy, out_vld, done}, 0);
        mon_on = 1;
        run_frame(0, 1'b0, 0, 0, 0);      // full-scale average
        run_frame(1, 1'b1, 3, 7, 4);      // gradient, flips mid-band, stray start
        run_frame(2, 1'b1, 0, 0, 0);      // checkerboard binomial
        run_frame(3, 1'b0, 9, 0, 12);     // pseudo-random
        run_frame(3, 1'b1, 2, 14, 0);
        run_frame(4, 1'b0, 0, 0, 0);      // zeros
        chk(q.size() == 0, "R7 no results left", q.size(), 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        mismatched++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule